// File: doc/BRIEF.md
# Sprite Row Two-Color Pixel Unit

This block turns one sprite row into a stream of pixels. A job carries the sprite's attributes: a 4-bit main color, two link bits (X and Y), a half-width flag, a two-color enable and a double-height request. After it accepts a job, the unit pulls the row's pattern words from an upstream source. It then emits one pixel per accepted transfer. Each pixel carries an opaque flag and a 4-bit color.

In plain mode each pixel takes one pattern bit. In two-color mode each pixel takes two bits, and a nonzero code picks either the main color or a second color. The second color is derived from the main color by a transform that only the link bits select. The half-width flag overrides the row length of two-color mode, but the other effect of two-color mode stays: it still forbids double-height linking. A plain status pin reports whether linking is allowed for the job in progress.

All three streams use valid/ready. A transfer happens on a rising clock edge where both are high. The unit drops job_ready while it works on a row. It raises pat_ready for exactly one word at a time and waits as long as needed for pat_valid. While pix_ready is low it holds the current pixel unchanged. pat_ready never depends on pat_valid, and pix_valid never depends on pix_ready.

Top module: `spr2c_row_unit`

## Requirements
- R1: After reset, job_ready is 1 and pix_valid, pat_ready, dbl_link_ok and pat_words are all 0.
- R2: A job is taken on a clock edge where job_valid and job_ready are both high. job_ready then stays 0, and job_valid has no effect, until the edge that accepts the last pixel of the row. job_ready is 1 again in the following cycle.
- R3: While a job is in progress, pat_words shows how many pattern words the row needs, and pat_ready is raised once for each of them, never together with pix_valid. With WORD_BITS=8 and ROW_PIX=16 the counts are: plain full 2, plain half 1, two-color full 4, two-color half 2.
- R4: Pixels leave in order, starting from bit 0 of the first word. In plain mode, pattern bit 0 gives a transparent pixel with color 0, and pattern bit 1 gives an opaque pixel with the main color. The link bits have no effect in plain mode.
- R5: In two-color mode each pixel takes the next two bits, read low bit first. Code 0 is transparent with color 0, code 1 is opaque with the main color, and codes 2 and 3 are opaque with the derived color.
- R6: With both link bits clear, the derived color equals the main color.
- R7: With exactly one link bit set, the derived color is the main color with bits 3..1 rotated up by one: new bit 3 = old bit 2, new bit 2 = old bit 1, new bit 1 = old bit 3.
- R8: With both link bits set, the derived color is the main color with bits 3..1 inverted.
- R9: Bit 0 of every opaque pixel's color equals bit 0 of the main color.
- R10: With the half-width flag set, the row has ROW_PIX/2 pixels, in either mode. Otherwise it has ROW_PIX pixels. pix_last is high only on the final pixel.
- R11: During a job, dbl_link_ok equals the double-height request AND NOT two-color, whatever the half-width flag is. It is 0 when the unit is idle.
- R12: While pix_valid is high and pix_ready is low, pix_opaque, pix_color and pix_last hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| job_valid | input | 1 | Job offered |
| job_ready | output | 1 | Unit idle, ready to take a job |
| job_color | input | 4 | Main sprite color |
| job_link_x | input | 1 | Link X bit |
| job_link_y | input | 1 | Link Y bit |
| job_half | input | 1 | Half-width row |
| job_two_color | input | 1 | Two-color mode enable |
| job_dbl_link | input | 1 | Double-height link request |
| pat_valid | input | 1 | Pattern word offered |
| pat_ready | output | 1 | Unit wants the next pattern word |
| pat_data | input | WORD_BITS (8) | Pattern word, pixel 0 in the low bits |
| pat_words | output | WCNT_W (3) | Number of words the current row needs |
| pix_valid | output | 1 | Pixel offered |
| pix_ready | input | 1 | Consumer takes the pixel |
| pix_opaque | output | 1 | Pixel is opaque |
| pix_color | output | 4 | Pixel color, 0 when transparent |
| pix_last | output | 1 | Final pixel of the row |
| dbl_link_ok | output | 1 | Double-height linking allowed for this job |

## Verification
The bench builds the unit with its default parameters, WORD_BITS=8 and ROW_PIX=16. With these values every word count (1, 2 and 4) occurs, as do both row lengths, so the handoff between pattern words and the final-pixel flag is exercised for each mode combination. Pixel back-pressure is toggled on some rows, and every main color is swept through the rotate and invert transforms.

// File: rtl/spr2c_pkg.sv
`timescale 1ns/1ps
package spr2c_pkg;
  localparam int COLOR_W = 4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_EMIT = 2'd2
  } row_state_e;

  typedef struct packed {
    logic [COLOR_W-1:0] color;
    logic               link_x;
    logic               link_y;
    logic               two_color;
  } row_attr_t;
endpackage

// File: rtl/spr2c_color_xform.sv
`timescale 1ns/1ps
module spr2c_color_xform
  import spr2c_pkg::*;
(
  input  logic [COLOR_W-1:0] main_color,
  input  logic               link_x,
  input  logic               link_y,
  output logic [COLOR_W-1:0] alt_color
);
  // Only the link bits steer the transform; bit 0 always passes through.
  always_comb begin
    unique case ({link_x, link_y})
      2'b00:   alt_color = main_color;
      2'b11:   alt_color = {~main_color[3:1], main_color[0]};
      default: alt_color = {main_color[2], main_color[1], main_color[3], main_color[0]};
    endcase
  end
endmodule

// File: rtl/spr2c_row_plan.sv
`timescale 1ns/1ps
module spr2c_row_plan #(
  parameter int WORD_BITS = 8,
  parameter int ROW_PIX   = 16,
  parameter int WCNT_W    = 3,
  parameter int PCNT_W    = 4
) (
  input  logic              half,
  input  logic              two_color,
  input  logic              dbl_link,
  output logic [WCNT_W-1:0] words,
  output logic [PCNT_W-1:0] pix_per_word,
  output logic              link_ok
);
  localparam int PLAIN_FULL = ROW_PIX / WORD_BITS;
  localparam int PLAIN_HALF = ROW_PIX / (2 * WORD_BITS);
  localparam int DUO_FULL   = (2 * ROW_PIX) / WORD_BITS;
  localparam int DUO_HALF   = ROW_PIX / WORD_BITS;

  always_comb begin
    unique case ({two_color, half})
      2'b00: words = WCNT_W'(PLAIN_FULL);
      2'b01: words = WCNT_W'(PLAIN_HALF);
      2'b10: words = WCNT_W'(DUO_FULL);
      default: words = WCNT_W'(DUO_HALF);
    endcase
  end

  assign pix_per_word = two_color ? PCNT_W'(WORD_BITS / 2) : PCNT_W'(WORD_BITS);
  // Half width shortens the row only; two-color still blocks linking.
  assign link_ok = dbl_link & ~two_color;
endmodule

// File: rtl/spr2c_pix_shift.sv
`timescale 1ns/1ps
module spr2c_pix_shift #(
  parameter int WORD_BITS = 8,
  parameter int PCNT_W    = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [WORD_BITS-1:0] load_word,
  input  logic [PCNT_W-1:0]    load_cnt,
  input  logic                 two_color,
  input  logic                 advance,
  output logic [1:0]           code,
  output logic                 last_in_word
);
  logic [WORD_BITS-1:0] sh_q;
  logic [PCNT_W-1:0]    left_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q   <= '0;
      left_q <= '0;
    end else if (load) begin
      sh_q   <= load_word;
      left_q <= load_cnt;
    end else if (advance) begin
      sh_q   <= two_color ? (sh_q >> 2) : (sh_q >> 1);
      left_q <= left_q - PCNT_W'(1);
    end
  end

  assign code         = two_color ? sh_q[1:0] : {1'b0, sh_q[0]};
  assign last_in_word = (left_q == PCNT_W'(1));
endmodule

// File: rtl/spr2c_row_unit.sv
`timescale 1ns/1ps
module spr2c_row_unit
  import spr2c_pkg::*;
#(
  parameter  int WORD_BITS = 8,
  parameter  int ROW_PIX   = 16,
  localparam int MAXW      = (2 * ROW_PIX) / WORD_BITS,
  localparam int WCNT_W    = $clog2(MAXW + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 job_valid,
  output logic                 job_ready,
  input  logic [3:0]           job_color,
  input  logic                 job_link_x,
  input  logic                 job_link_y,
  input  logic                 job_half,
  input  logic                 job_two_color,
  input  logic                 job_dbl_link,
  input  logic                 pat_valid,
  output logic                 pat_ready,
  input  logic [WORD_BITS-1:0] pat_data,
  output logic [WCNT_W-1:0]    pat_words,
  output logic                 pix_valid,
  input  logic                 pix_ready,
  output logic                 pix_opaque,
  output logic [3:0]           pix_color,
  output logic                 pix_last,
  output logic                 dbl_link_ok
);
  localparam int PCNT_W = $clog2(WORD_BITS + 1);

  row_state_e        state_q;
  row_attr_t         att_q;
  logic [WCNT_W-1:0] words_left_q;
  logic [WCNT_W-1:0] words_q;
  logic [PCNT_W-1:0] ppw_q;
  logic              link_q;

  logic [WCNT_W-1:0] plan_words;
  logic [PCNT_W-1:0] plan_ppw;
  logic              plan_link;
  logic [1:0]        code;
  logic              last_in_word;
  logic [3:0]        alt_color;
  logic              job_fire, pat_fire, pix_fire, row_done;

  assign job_ready = (state_q == ST_IDLE);
  assign pat_ready = (state_q == ST_LOAD);
  assign pix_valid = (state_q == ST_EMIT);
  assign job_fire  = job_valid & job_ready;
  assign pat_fire  = pat_valid & pat_ready;
  assign pix_fire  = pix_valid & pix_ready;
  assign row_done  = pix_fire & last_in_word & (words_left_q == WCNT_W'(1));

  spr2c_row_plan #(
    .WORD_BITS(WORD_BITS), .ROW_PIX(ROW_PIX), .WCNT_W(WCNT_W), .PCNT_W(PCNT_W)
  ) plan_i (
    .half        (job_half),
    .two_color   (job_two_color),
    .dbl_link    (job_dbl_link),
    .words       (plan_words),
    .pix_per_word(plan_ppw),
    .link_ok     (plan_link)
  );

  spr2c_pix_shift #(
    .WORD_BITS(WORD_BITS), .PCNT_W(PCNT_W)
  ) shift_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (pat_fire),
    .load_word   (pat_data),
    .load_cnt    (ppw_q),
    .two_color   (att_q.two_color),
    .advance     (pix_fire),
    .code        (code),
    .last_in_word(last_in_word)
  );

  spr2c_color_xform xform_i (
    .main_color(att_q.color),
    .link_x    (att_q.link_x),
    .link_y    (att_q.link_y),
    .alt_color (alt_color)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      att_q        <= '0;
      words_left_q <= '0;
      words_q      <= '0;
      ppw_q        <= '0;
      link_q       <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (job_fire) begin
          att_q        <= '{color: job_color, link_x: job_link_x,
                            link_y: job_link_y, two_color: job_two_color};
          words_left_q <= plan_words;
          words_q      <= plan_words;
          ppw_q        <= plan_ppw;
          link_q       <= plan_link;
          state_q      <= ST_LOAD;
        end
        ST_LOAD: if (pat_fire) state_q <= ST_EMIT;
        ST_EMIT: if (pix_fire && last_in_word) begin
          words_left_q <= words_left_q - WCNT_W'(1);
          if (row_done) begin
            state_q <= ST_IDLE;
            words_q <= '0;
            link_q  <= 1'b0;
          end else begin
            state_q <= ST_LOAD;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    pix_opaque = pix_valid & (code != 2'b00);
    pix_color  = 4'h0;
    if (pix_opaque) pix_color = code[1] ? alt_color : att_q.color;
  end

  assign pix_last    = pix_valid & last_in_word & (words_left_q == WCNT_W'(1));
  assign pat_words   = words_q;
  assign dbl_link_ok = link_q;
endmodule

// File: rtl/spr2c_row_chk.sv
`timescale 1ns/1ps
module spr2c_row_chk #(
  parameter int ROW_PIX = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic       job_valid,
  input logic       job_ready,
  input logic       job_half,
  input logic       pat_ready,
  input logic       pix_valid,
  input logic       pix_ready,
  input logic       pix_opaque,
  input logic [3:0] pix_color,
  input logic       pix_last,
  input logic       dbl_link_ok,
  input logic [3:0] main_color
);
  localparam int CW = $clog2(ROW_PIX + 1) + 1;
  logic [CW-1:0] cnt_q, exp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      exp_q <= '0;
    end else if (job_valid && job_ready) begin
      cnt_q <= '0;
      exp_q <= job_half ? CW'(ROW_PIX / 2) : CW'(ROW_PIX);
    end else if (pix_valid && pix_ready) begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  p_busy_after_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
    job_valid && job_ready |=> !job_ready);
  p_idle_after_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && pix_ready && pix_last |=> job_ready);
  p_one_phase_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({job_ready, pat_ready, pix_valid}));
  p_clear_color_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && !pix_opaque |-> pix_color == 4'h0);
  p_lsb_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && pix_opaque |-> pix_color[0] == main_color[0]);
  p_row_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && pix_last |-> (cnt_q + CW'(1)) == exp_q);
  p_link_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    job_ready |-> !dbl_link_ok);
  p_hold_pixel_r12: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && !pix_ready |=> pix_valid && $stable(pix_color)
      && $stable(pix_opaque) && $stable(pix_last));
endmodule

bind spr2c_row_unit spr2c_row_chk #(.ROW_PIX(ROW_PIX)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .job_valid  (job_valid),
  .job_ready  (job_ready),
  .job_half   (job_half),
  .pat_ready  (pat_ready),
  .pix_valid  (pix_valid),
  .pix_ready  (pix_ready),
  .pix_opaque (pix_opaque),
  .pix_color  (pix_color),
  .pix_last   (pix_last),
  .dbl_link_ok(dbl_link_ok),
  .main_color (att_q.color)
);

// File: tb/spr2c_row_unit_tb_top.sv
`timescale 1ns/1ps
module spr2c_row_unit_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       job_valid = 1'b0;
  logic       job_ready;
  logic [3:0] job_color = 4'h0;
  logic       job_link_x = 1'b0, job_link_y = 1'b0, job_half = 1'b0;
  logic       job_two_color = 1'b0, job_dbl_link = 1'b0;
  logic       pat_valid = 1'b0;
  logic       pat_ready;
  logic [7:0] pat_data = 8'h00;
  logic [2:0] pat_words;
  logic       pix_valid;
  logic       pix_ready = 1'b0;
  logic       pix_opaque;
  logic [3:0] pix_color;
  logic       pix_last;
  logic       dbl_link_ok;

  int checks = 0;
  int errors = 0;
  bit reported = 1'b0;

  always #2 clk = ~clk;

  spr2c_row_unit dut_i (
    .clk(clk), .rst_n(rst_n), .job_valid(job_valid), .job_ready(job_ready),
    .job_color(job_color), .job_link_x(job_link_x), .job_link_y(job_link_y),
    .job_half(job_half), .job_two_color(job_two_color), .job_dbl_link(job_dbl_link),
    .pat_valid(pat_valid), .pat_ready(pat_ready), .pat_data(pat_data),
    .pat_words(pat_words), .pix_valid(pix_valid), .pix_ready(pix_ready),
    .pix_opaque(pix_opaque), .pix_color(pix_color), .pix_last(pix_last),
    .dbl_link_ok(dbl_link_ok)
  );

  // {color[41:38], link_x, link_y, half, two_color, dbl_link, backpressure, pattern[31:0]}
  localparam logic [41:0] VEC [0:7] = '{
    {4'h5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0000_A53C},
    {4'hB, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 32'h0000_00C3},
    {4'h6, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 32'hE4E4_1B1B},
    {4'h9, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 32'h9C6A_F00F},
    {4'hD, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 32'h3210_FEDC},
    {4'h3, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 32'h0000_B4E1},
    {4'h0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 32'hFFFF_AAAA},
    {4'hF, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 32'h8001_7FFE}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] derive(input logic [3:0] c, input logic lx, input logic ly);
    if (lx && ly)      return c ^ 4'b1110;
    else if (lx || ly) return {c[2], c[1], c[3], c[0]};
    else               return c;
  endfunction

  task automatic run_job(input logic [41:0] v, input bit hold_busy, input bit lsb_check);
    logic [3:0]  c    = v[41:38];
    logic        lx   = v[37];
    logic        ly   = v[36];
    logic        hf   = v[35];
    logic        two  = v[34];
    logic        dbl  = v[33];
    logic        bp   = v[32];
    logic [31:0] pat  = v[31:0];
    int npix   = hf ? 8 : 16;
    int nwords = two ? (hf ? 2 : 4) : (hf ? 1 : 2);
    int wi = 0, pi = 0, cyc = 0;
    bit stalled = 1'b0, done = 1'b0;
    logic [1:0] code;
    logic       eop;
    logic [3:0] ecol;
    string      tag;
    @(negedge clk);
    check(job_ready === 1'b1, "R2", job_ready, 1);
    job_valid = 1'b1; job_color = c; job_link_x = lx; job_link_y = ly;
    job_half = hf; job_two_color = two; job_dbl_link = dbl;
    @(negedge clk);
    if (hold_busy) begin
      job_color = ~c; job_link_x = ~lx; job_half = ~hf; job_two_color = ~two;
    end else job_valid = 1'b0;
    check(pat_words == 3'(nwords), "R3", pat_words, nwords);
    check(dbl_link_ok == (dbl & ~two), "R11", dbl_link_ok, dbl & ~two);
    while (!done && cyc < 400) begin
      cyc++;
      pat_valid = pat_ready;
      pat_data  = pat_ready ? pat[wi*8 +: 8] : 8'h00;
      if (pat_ready) begin
        check(!pix_valid, "R3", pix_valid, 0);
        wi++;
      end
      if (hold_busy) check(job_ready == 1'b0, "R2", job_ready, 0);
      if (pix_valid) begin
        code = two ? pat[2*pi +: 2] : {1'b0, pat[pi]};
        eop  = (code != 2'b00);
        ecol = !eop ? 4'h0 : (code[1] ? derive(c, lx, ly) : c);
        if (stalled)      tag = "R12";
        else if (!two)    tag = "R4";
        else if (!code[1]) tag = "R5";
        else if (lx && ly) tag = "R8";
        else if (lx || ly) tag = "R7";
        else               tag = "R6";
        check(pix_opaque == eop, tag, pix_opaque, eop);
        check(pix_color == ecol, tag, pix_color, ecol);
        check(pix_last == (pi == npix - 1), "R10", pix_last, pi == npix - 1);
        if (lsb_check && eop) check(pix_color[0] == c[0], "R9", pix_color[0], c[0]);
        pix_ready = bp ? cyc[0] : 1'b1;
        stalled = !pix_ready;
        if (pix_ready) begin
          if (pi == npix - 1) done = 1'b1;
          pi++;
        end
      end else pix_ready = 1'b0;
      @(negedge clk);
    end
    job_valid = 1'b0; pat_valid = 1'b0; pix_ready = 1'b0;
    check(job_ready == 1'b1 && pix_valid == 1'b0, "R2", job_ready, 1);
    check(wi == nwords, "R3", wi, nwords);
    check(pi == npix, "R10", pi, npix);
    check(dbl_link_ok == 1'b0, "R11", dbl_link_ok, 0);
  endtask

  initial begin
    #(4 * 150000);
    if (!reported) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      reported = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(job_ready == 1'b1, "R1", job_ready, 1);
    check(pix_valid == 1'b0, "R1", pix_valid, 0);
    check(pat_ready == 1'b0, "R1", pat_ready, 0);
    check(dbl_link_ok == 1'b0 && pat_words == 3'd0, "R1", dbl_link_ok, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(job_ready == 1'b1 && pix_valid == 1'b0, "R1", pix_valid, 0);

    for (int i = 0; i < 8; i++) run_job(VEC[i], 1'b0, 1'b1);

    // R2: job_valid held with other attributes while busy has no effect
    run_job({4'hA, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 32'h1B2D_E478}, 1'b1, 1'b0);

    // R8, R9: invert sweep over every main color, half width two-color
    for (int c = 0; c < 16; c++)
      run_job({4'(c), 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0000_E4AA}, 1'b0, 1'b1);
    // R7, R9: rotate sweep over every main color
    for (int c = 0; c < 16; c++)
      run_job({4'(c), 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 32'h0000_A9E6}, 1'b0, 1'b1);

    // R11: half width does not restore linking in two-color mode
    run_job({4'h7, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 32'h0000_5A5A}, 1'b0, 1'b0);
    // R11: plain half width keeps linking
    run_job({4'h7, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 32'h0000_0081}, 1'b0, 1'b0);

    // R1: reset in the middle of a row returns to idle
    @(negedge clk);
    job_valid = 1'b1; job_two_color = 1'b1; job_half = 1'b0;
    @(negedge clk);
    job_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check(job_ready == 1'b1 && pat_ready == 1'b0 && pix_valid == 1'b0, "R1", job_ready, 1);
    check(dbl_link_ok == 1'b0 && pat_words == 3'd0, "R1", pat_words, 0);
    rst_n = 1'b1;
    run_job(VEC[0], 1'b0, 1'b0);

    if (!reported) begin
      reported = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule